// File: doc/BRIEF.md
# Decode-Stage Next-PC Resolver

This block picks the next fetch address for a five-stage, in-order pipeline that settles control flow while the instruction sits in decode. The decoder supplies a valid bit and five control flags: direct jump, link, register jump, branch, and branch polarity. The datapath supplies the incremented PC, the sign-extended offset, the 26-bit jump index and the branch source register, already forwarded. The block computes every candidate target, tests the source against zero and chooses one target by fixed priority. It raises a redirect that loads the new PC and squashes the instruction being fetched. For linking jumps it also produces the register-file write request for the return address.

The block remembers one bit between cycles: whether it redirected on the previous cycle. If it did, the instruction now in decode is the one that was squashed in fetch. That instruction can neither redirect nor link.

Top module: `npc_resolver`

## Requirements
- R1: While reset is low and on the first cycle after it, no squash state is held. A jump presented on the first cycle after reset redirects. With all control flags low, `redirect` = 0, `link_we` = 0 and `next_pc` = `pc_plus4`.
- R2: A taken branch gives `next_pc` = `pc_plus4` + (`imm_ext` × 4), modulo 2^32.
- R3: A branch is taken when `br_en` = 1 and the source test holds. With `br_on_nz` = 0 the test is `rs_val` == 0. With `br_on_nz` = 1 the test is `rs_val` != 0. With `br_en` = 0 nothing is taken.
- R4: A direct jump gives `next_pc` = {`pc_plus4`[31:28], `jidx`, 2'b00}.
- R5: A register jump (`jreg_en` = 1) gives `next_pc` = `rs_val`.
- R6: When several sources are active, `jreg_en` takes precedence over `jump_en`. `jump_en` takes precedence over a taken branch, and a taken branch takes precedence over `pc_plus4`. With nothing active, `next_pc` = `pc_plus4`.
- R7: `redirect` = 1 exactly when a live decode instruction has `jump_en`, `jreg_en` or a taken branch.
- R8: `link_we` = 1 exactly when a live decode instruction has `link_en` together with `jump_en` or `jreg_en`. In that case `link_addr` = 31 and `link_data` = `pc_plus4` + 4, which is the fetch address plus 8.
- R9: On the cycle after a redirect, the decode instruction is squashed. `redirect` = 0, `link_we` = 0 and `next_pc` = `pc_plus4`, whatever the control flags are.
- R10: With `id_valid` = 0, the outputs are `redirect` = 0, `link_we` = 0 and `next_pc` = `pc_plus4`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| id_valid | input | 1 | Decode slot holds a real instruction |
| jump_en | input | 1 | Direct jump to the index target |
| link_en | input | 1 | Jump also writes the return address |
| jreg_en | input | 1 | Jump to the register operand |
| br_en | input | 1 | Conditional branch on zero test |
| br_on_nz | input | 1 | 0: taken if zero, 1: taken if non-zero |
| pc_plus4 | input | 32 | Address of decode instruction plus 4 |
| imm_ext | input | 32 | Sign-extended word offset |
| jidx | input | 26 | Direct jump index |
| rs_val | input | 32 | Forwarded source register value |
| next_pc | output | 32 | Selected next fetch address |
| redirect | output | 1 | Load next_pc and squash the fetched instruction |
| link_we | output | 1 | Return-address write enable |
| link_addr | output | 5 | Return-address register index |
| link_data | output | 32 | Return-address value |

## Verification
The bench sweeps every combination of the six control inputs against source values of zero, one, all ones and the sign bit alone. It does this under several PC, offset and index patterns, with back-to-back redirects arising naturally. A wrong priority order would show up as the wrong target when jump, register jump and branch flags overlap. An inverted polarity test would send a zero source the wrong way. A missing squash bit would let the instruction after a jump redirect or link a second time. Offsets with the sign bit set, and PC values near the top of the address space, catch a target adder that drops the shift or the sign. They also catch a jump target that takes its upper bits from the wrong place.

// File: rtl/npc_pkg.sv
package npc_pkg;

  typedef enum logic [1:0] {
    SEL_SEQ  = 2'd0,
    SEL_BR   = 2'd1,
    SEL_JMP  = 2'd2,
    SEL_JREG = 2'd3
  } npc_sel_e;

  typedef struct packed {
    logic live;
    logic jump;
    logic link;
    logic jreg;
    logic branch;
    logic on_nz;
  } npc_ctl_t;

endpackage

// File: rtl/npc_target_calc.sv
module npc_target_calc #(
  parameter int XLEN  = 32,
  parameter int IDX_W = 26
) (
  input  logic [XLEN-1:0]  pc_plus4,
  input  logic [XLEN-1:0]  imm_ext,
  input  logic [IDX_W-1:0] jidx,
  output logic [XLEN-1:0]  br_tgt,
  output logic [XLEN-1:0]  jmp_tgt,
  output logic [XLEN-1:0]  lnk_val
);
  localparam int REGION_W = XLEN - IDX_W - 2;
  localparam logic [XLEN-1:0] WORD_STEP = XLEN'(4);

  function automatic logic [XLEN-1:0] calc_branch(input logic [XLEN-1:0] seq,
                                                  input logic [XLEN-1:0] off);
    return seq + {off[XLEN-3:0], 2'b00};
  endfunction

  function automatic logic [XLEN-1:0] calc_jump(input logic [XLEN-1:0] seq,
                                                input logic [IDX_W-1:0] idx);
    return {seq[XLEN-1 -: REGION_W], idx, 2'b00};
  endfunction

  function automatic logic [XLEN-1:0] calc_link(input logic [XLEN-1:0] seq);
    return seq + WORD_STEP;
  endfunction

  assign br_tgt  = calc_branch(pc_plus4, imm_ext);
  assign jmp_tgt = calc_jump(pc_plus4, jidx);
  assign lnk_val = calc_link(pc_plus4);
endmodule

// File: rtl/npc_cond.sv
module npc_cond #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            br_en,
  input  logic            on_nz,
  input  logic [XLEN-1:0] src,
  output logic            src_zero,
  output logic            taken
);
  assign src_zero = (src == '0);
  assign taken    = br_en & (src_zero ^ on_nz);

  p_no_branch_no_take_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !br_en |-> !taken);
  p_zero_eq_taken_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (br_en && !on_nz && src == '0) |-> taken);
endmodule

// File: rtl/npc_select.sv
module npc_select
  import npc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  npc_ctl_t        ctl,
  input  logic            taken,
  input  logic [XLEN-1:0] pc_plus4,
  input  logic [XLEN-1:0] br_tgt,
  input  logic [XLEN-1:0] jmp_tgt,
  input  logic [XLEN-1:0] reg_tgt,
  output npc_sel_e        sel,
  output logic [XLEN-1:0] next_pc,
  output logic            redirect
);
  always_comb begin
    sel = SEL_SEQ;
    if (ctl.live) begin
      if (ctl.jreg)      sel = SEL_JREG;
      else if (ctl.jump) sel = SEL_JMP;
      else if (taken)    sel = SEL_BR;
    end
  end

  always_comb begin
    unique case (sel)
      SEL_JREG: next_pc = reg_tgt;
      SEL_JMP:  next_pc = jmp_tgt;
      SEL_BR:   next_pc = br_tgt;
      default:  next_pc = pc_plus4;
    endcase
  end

  assign redirect = (sel != SEL_SEQ);
endmodule

// File: rtl/npc_resolver.sv
module npc_resolver
  import npc_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int IDX_W    = 26,
  parameter int REG_AW   = 5,
  parameter int LINK_REG = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              id_valid,
  input  logic              jump_en,
  input  logic              link_en,
  input  logic              jreg_en,
  input  logic              br_en,
  input  logic              br_on_nz,
  input  logic [XLEN-1:0]   pc_plus4,
  input  logic [XLEN-1:0]   imm_ext,
  input  logic [IDX_W-1:0]  jidx,
  input  logic [XLEN-1:0]   rs_val,
  output logic [XLEN-1:0]   next_pc,
  output logic              redirect,
  output logic              link_we,
  output logic [REG_AW-1:0] link_addr,
  output logic [XLEN-1:0]   link_data
);
  localparam int REGION_W = XLEN - IDX_W - 2;
  localparam logic [REG_AW-1:0] LINK_IDX = REG_AW'(LINK_REG);

  // squash state: the decode slot holds a killed instruction
  logic     kill_q;
  logic     live;
  logic     taken;
  logic     src_zero;
  logic     is_jump;
  npc_ctl_t ctl;
  npc_sel_e sel;
  logic [XLEN-1:0] br_tgt, jmp_tgt, lnk_val;

  assign live = id_valid & ~kill_q;

  always_comb begin
    ctl        = '0;
    ctl.live   = live;
    ctl.jump   = jump_en;
    ctl.link   = link_en;
    ctl.jreg   = jreg_en;
    ctl.branch = br_en;
    ctl.on_nz  = br_on_nz;
  end

  npc_target_calc #(.XLEN(XLEN), .IDX_W(IDX_W)) u_tgt (
    .pc_plus4 (pc_plus4),
    .imm_ext  (imm_ext),
    .jidx     (jidx),
    .br_tgt   (br_tgt),
    .jmp_tgt  (jmp_tgt),
    .lnk_val  (lnk_val)
  );

  npc_cond #(.XLEN(XLEN)) u_cond (
    .clk      (clk),
    .rst_n    (rst_n),
    .br_en    (ctl.branch),
    .on_nz    (ctl.on_nz),
    .src      (rs_val),
    .src_zero (src_zero),
    .taken    (taken)
  );

  npc_select #(.XLEN(XLEN)) u_sel (
    .ctl      (ctl),
    .taken    (taken),
    .pc_plus4 (pc_plus4),
    .br_tgt   (br_tgt),
    .jmp_tgt  (jmp_tgt),
    .reg_tgt  (rs_val),
    .sel      (sel),
    .next_pc  (next_pc),
    .redirect (redirect)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) kill_q <= 1'b0;
    else        kill_q <= redirect;
  end

  assign is_jump   = ctl.jump | ctl.jreg;
  assign link_we   = ctl.live & ctl.link & is_jump;
  assign link_addr = LINK_IDX;
  assign link_data = lnk_val;

  p_one_cycle_redirect_r9: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> (!redirect && !link_we));
  p_idle_keeps_seq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !redirect |-> next_pc == pc_plus4);
  p_redirect_needs_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> id_valid);
  p_link_only_on_redirect_r8: assert property (@(posedge clk) disable iff (!rst_n)
    link_we |-> (redirect && sel != SEL_BR));
  p_jreg_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect && jreg_en) |-> next_pc == rs_val);
  p_jump_region_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect && jump_en && !jreg_en) |->
      (next_pc[XLEN-1 -: REGION_W] == pc_plus4[XLEN-1 -: REGION_W] && next_pc[1:0] == 2'b00));
  p_branch_needs_test_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_BR) |-> (br_en && (src_zero != br_on_nz)));
endmodule

// File: tb/npc_resolver_tb.sv
module npc_resolver_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        id_valid = 1'b0, jump_en = 1'b0, link_en = 1'b0, jreg_en = 1'b0;
  logic        br_en = 1'b0, br_on_nz = 1'b0;
  logic [31:0] pc_plus4 = 32'd4, imm_ext = '0, rs_val = '0;
  logic [25:0] jidx = '0;
  logic [31:0] next_pc, link_data;
  logic        redirect, link_we;
  logic [4:0]  link_addr;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;
  bit model_kill = 1'b0;

  always #10 clk = ~clk;

  npc_resolver u_dut (
    .clk(clk), .rst_n(rst_n), .id_valid(id_valid), .jump_en(jump_en),
    .link_en(link_en), .jreg_en(jreg_en), .br_en(br_en), .br_on_nz(br_on_nz),
    .pc_plus4(pc_plus4), .imm_ext(imm_ext), .jidx(jidx), .rs_val(rs_val),
    .next_pc(next_pc), .redirect(redirect), .link_we(link_we),
    .link_addr(link_addr), .link_data(link_data)
  );

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // one decode cycle: drive at negedge, compare, then track squash state
  task automatic step(input bit v, input bit j, input bit l, input bit jr,
                      input bit b, input bit nz, input logic [31:0] p4,
                      input logic [31:0] imm, input logic [25:0] idx,
                      input logic [31:0] rs);
    bit ev, tk, exp_red, exp_lwe;
    logic [31:0] exp_pc;
    string pc_tag, red_tag;
    int active;
    @(negedge clk);
    id_valid = v; jump_en = j; link_en = l; jreg_en = jr; br_en = b; br_on_nz = nz;
    pc_plus4 = p4; imm_ext = imm; jidx = idx; rs_val = rs;
    #2;
    ev = v && !model_kill;
    tk = b && ((rs == 32'd0) != nz);
    exp_red = ev && (jr || j || tk);
    exp_lwe = ev && l && (j || jr);
    active = int'(jr) + int'(j) + int'(tk);
    if (!ev)      exp_pc = p4;
    else if (jr)  exp_pc = rs;
    else if (j)   exp_pc = {p4[31:28], idx, 2'b00};
    else if (tk)  exp_pc = p4 + imm * 32'd4;
    else          exp_pc = p4;
    if (model_kill)      begin pc_tag = "R9";  red_tag = "R9";  end
    else if (!v)         begin pc_tag = "R10"; red_tag = "R10"; end
    else begin
      if (active > 1)    pc_tag = "R6";
      else if (jr)       pc_tag = "R5";
      else if (j)        pc_tag = "R4";
      else if (tk)       pc_tag = "R2";
      else               pc_tag = "R6";
      red_tag = (b && !j && !jr) ? "R3" : "R7";
    end
    check(pc_tag, "next_pc", next_pc, exp_pc);
    check(red_tag, "redirect", {31'd0, redirect}, {31'd0, exp_red});
    check(model_kill ? "R9" : "R8", "link_we", {31'd0, link_we}, {31'd0, exp_lwe});
    if (exp_lwe) begin
      check("R8", "link_data", link_data, p4 + 32'd4);
      check("R8", "link_addr", {27'd0, link_addr}, 32'd31);
    end
    @(posedge clk);
    model_kill = exp_red;
  endtask

  initial begin
    logic [31:0] pcs [4];
    logic [31:0] imms [5];
    logic [31:0] rss [4];
    pcs[0] = 32'h0000_0004; pcs[1] = 32'hF000_0FFC;
    pcs[2] = 32'h7FFF_FFFC; pcs[3] = 32'h1234_5678;
    imms[0] = 32'h0000_0000; imms[1] = 32'h0000_0001; imms[2] = 32'hFFFF_FFFF;
    imms[3] = 32'hFFFF_8000; imms[4] = 32'h0000_7FFF;
    rss[0] = 32'h0; rss[1] = 32'h1; rss[2] = 32'hFFFF_FFFF; rss[3] = 32'h8000_0000;

    // R1: reset holds no squash state even with a jump applied
    @(negedge clk);
    id_valid = 1'b1; jump_en = 1'b1; jidx = 26'h155_5555;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #2;
    check("R1", "redirect after reset", {31'd0, redirect}, 32'd1);
    check("R1", "next_pc after reset", next_pc, {4'h0, 26'h155_5555, 2'b00});
    @(posedge clk);
    model_kill = 1'b1;
    step(0, 0, 0, 0, 0, 0, 32'h100, 0, 0, 0);
    step(1, 0, 0, 0, 0, 0, 32'h200, 32'h10, 26'h3, 32'h0);
    check("R1", "idle link_we", {31'd0, link_we}, 32'd0);

    // R9: back-to-back jump and link, second one squashed
    step(1, 1, 1, 0, 0, 0, 32'h4000_0010, 0, 26'h0ABCDE, 0);
    step(1, 1, 1, 0, 0, 0, 32'h4000_0014, 0, 26'h012345, 0);
    step(1, 0, 0, 1, 0, 0, 32'h4000_0018, 0, 0, 32'hDEAD_BEE0);

    // exhaustive control sweep across data patterns
    for (int p = 0; p < 4; p++)
      for (int r = 0; r < 4; r++)
        for (int c = 0; c < 64; c++)
          step(c[5], c[4], c[3], c[2], c[1], c[0], pcs[p], imms[(c + p) % 5],
               26'(32'h2A5_A5A5 ^ (c * 32'h1_0101)), rss[r]);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000 && !done) begin
        errors++;
        checks++;
        $display("FAIL watchdog expired at cycle %0d", cycles);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end
endmodule